// File: doc/BRIEF.md
# Dual-Thread Ready-Driven Issue Queue

This block is an out-of-order issue queue shared by two hardware threads. Each slot holds a micro-op: its own tag, the thread that owns it, the tags of its two source operands and one ready flag per source. A result broadcast (a valid strobe plus a destination tag) marks every waiting source with that tag as available. Once both sources of a micro-op are available it becomes a candidate. Each cycle the oldest candidate leaves the queue, and the thread that owns it plays no part in the choice.

Either thread may present one new micro-op per cycle, and both may be taken in the same cycle. The queue keeps a small number of slots in reserve for each thread, so one thread cannot fill the structure and lock the other out. A per-thread full flag tells the front end which thread to stall. When both threads compete for the very last free slot, they take turns winning it.

Top module: `dual_thread_issue_queue`

## Requirements
- R1: After reset the queue is empty, `disp_valid` is 0 and both bits of `full` are 0.
- R2: In every cycle that holds at least one candidate (both source flags set), `disp_valid` is 1. `disp_tag` and `disp_thread` then describe the candidate inserted earliest, whichever thread owns it, and that micro-op is removed at the next rising edge. At most one micro-op leaves per cycle.
- R3: A micro-op with either source flag clear is never dispatched.
- R4: When `wk_valid` is 1, every stored source whose tag equals `wk_tag` is marked available at the next edge. This includes the sources of a micro-op inserted in that same cycle. Such a micro-op can appear on the dispatch outputs in the following cycle, and not in the cycle of the broadcast.
- R5: When both threads are accepted in the same cycle, the thread 0 micro-op counts as older than the thread 1 micro-op.
- R6: Let F be DEPTH minus the total occupancy, and let O be RSV minus the occupancy of the other thread, or 0 if that is negative. `full[t]` is 1 when F is no greater than O. A thread holding fewer than RSV micro-ops therefore never sees its full flag set by the other thread's use.
- R7: If exactly one slot is free, neither thread is blocked by R6 and both request, only one is accepted and the other sees its `full` bit set in that cycle. Thread 0 wins the first such contest after reset, and the winner alternates on each later contest. Bit t of `full` belongs to thread t.
- R8: A micro-op presented while its thread's `full` bit is 1 is dropped and never dispatched.
- R9: The occupancy never exceeds DEPTH. With DEPTH micro-ops stored, `full` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 2 | Per-thread insert request, bit t for thread t |
| ins_tag | input | 2 x TAG_W | Micro-op tag per thread |
| ins_src_tag | input | 2 x 2 x TAG_W | Two source tags per thread |
| ins_src_rdy | input | 2 x 2 | Initial availability of each source, per thread |
| wk_valid | input | 1 | Result broadcast strobe |
| wk_tag | input | TAG_W | Destination tag of the broadcast result |
| full | output | 2 | Per-thread stall, bit t for thread t |
| disp_valid | output | 1 | A micro-op is dispatched this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched micro-op |
| disp_thread | output | 1 | Owning thread of the dispatched micro-op |

## Verification
The risky overlap is a result broadcast that lands in the same cycle as the insertion of a micro-op waiting on that result. If the match logic misses the new slot, the micro-op sleeps forever. A directed case inserts a micro-op whose only missing source is broadcast in that cycle and then expects it on the dispatch port exactly one cycle later. A second overlap is a dispatch that frees a slot in the cycle after a last-slot contest between both threads. A directed case runs two back-to-back contests and checks that the full flags name the loser, thread 1 first and then thread 0. Random traffic keeps broadcasts, dual inserts and dispatches colliding, and every cycle is compared with a queue model kept in the bench.

// File: rtl/iq_pkg.sv
package iq_pkg;

  localparam int NUM_THREADS = 2;

  // Entries still owed to a thread before it reaches its guaranteed minimum.
  function automatic int reserve_owed(int rsv, int occ_thread);
    return (occ_thread >= rsv) ? 0 : (rsv - occ_thread);
  endfunction

  // A thread may insert only when free space exceeds what is held for the other thread.
  function automatic logic no_headroom(int free_slots, int owed_other);
    return (free_slots - owed_other) <= 0;
  endfunction

endpackage

// File: rtl/iq_select.sv
module iq_select #(
  parameter int N  = 10,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Lowest index wins: the queue is kept compacted, so index order is age order.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/iq_admit.sv
module iq_admit
  import iq_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int RSV   = 2,
  parameter int CW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0][CW-1:0] occ,
  input  logic [1:0]         want,
  output logic [1:0]         full,
  output logic [1:0]         take,
  output logic               conflict
);

  int         free_slots;
  logic [1:0] tight;
  logic       pri;   // 0: thread 0 wins the next last-slot contest

  always_comb begin
    free_slots = DEPTH - int'(occ[0]) - int'(occ[1]);
    tight[0]   = no_headroom(free_slots, reserve_owed(RSV, int'(occ[1])));
    tight[1]   = no_headroom(free_slots, reserve_owed(RSV, int'(occ[0])));
    conflict   = (free_slots == 1) && !tight[0] && !tight[1] && (&want);
    full[0]    = tight[0] | (conflict & pri);
    full[1]    = tight[1] | (conflict & ~pri);
    take       = want & ~full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pri <= 1'b0;
    else if (conflict) pri <= ~pri;
  end

endmodule

// File: rtl/dual_thread_issue_queue.sv
module dual_thread_issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int RSV   = 2,
  parameter int TAG_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 ins_valid,
  input  logic [1:0][TAG_W-1:0]      ins_tag,
  input  logic [1:0][1:0][TAG_W-1:0] ins_src_tag,
  input  logic [1:0][1:0]            ins_src_rdy,
  input  logic                       wk_valid,
  input  logic [TAG_W-1:0]           wk_tag,
  output logic [1:0]                 full,
  output logic                       disp_valid,
  output logic [TAG_W-1:0]           disp_tag,
  output logic                       disp_thread
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    logic                  thr;
    logic [TAG_W-1:0]      tag;
    logic [1:0][TAG_W-1:0] stag;
    logic [1:0]            srdy;
  } ent_t;

  ent_t               q   [DEPTH];
  ent_t               q_n [DEPTH];
  logic [CW-1:0]      count, count_n;
  logic [DEPTH-1:0]   ent_ready;
  logic               disp_fire;
  logic [IW-1:0]      disp_idx;
  logic [1:0][CW-1:0] occ;
  logic [1:0]         take;
  logic               ins_conflict;

  function automatic logic [1:0] wake_bits(logic [1:0][TAG_W-1:0] st, logic [1:0] r,
                                           logic wv, logic [TAG_W-1:0] wt);
    logic [1:0] o;
    for (int s = 0; s < 2; s++) o[s] = r[s] | (wv && (st[s] == wt));
    return o;
  endfunction

  function automatic ent_t new_entry(logic t, logic [TAG_W-1:0] tg,
                                     logic [1:0][TAG_W-1:0] st, logic [1:0] r,
                                     logic wv, logic [TAG_W-1:0] wt);
    ent_t e;
    e.thr  = t;
    e.tag  = tg;
    e.stag = st;
    e.srdy = wake_bits(st, r, wv, wt);
    return e;
  endfunction

  // Occupancy per thread and candidate flags
  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < count) occ[q[i].thr] = occ[q[i].thr] + CW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_rdy
    assign ent_ready[g] = (CW'(g) < count) && (&q[g].srdy);
  end

  iq_select #(.N(DEPTH)) u_sel (
    .req   (ent_ready),
    .found (disp_fire),
    .idx   (disp_idx)
  );

  iq_admit #(.DEPTH(DEPTH), .RSV(RSV), .CW(CW)) u_adm (
    .clk      (clk),
    .rst_n    (rst_n),
    .occ      (occ),
    .want     (ins_valid),
    .full     (full),
    .take     (take),
    .conflict (ins_conflict)
  );

  assign disp_valid  = disp_fire;
  assign disp_tag    = q[disp_idx].tag;
  assign disp_thread = q[disp_idx].thr;

  // Next state: collapse the dispatched slot, apply wakeup, append arrivals
  always_comb begin
    logic [CW-1:0] base;
    logic [CW-1:0] slot_b;
    for (int i = 0; i < DEPTH; i++) begin
      if (disp_fire && (IW'(i) >= disp_idx)) begin
        if (i == DEPTH - 1) q_n[i] = '0;
        else                q_n[i] = q[(i + 1) % DEPTH];
      end else begin
        q_n[i] = q[i];
      end
      q_n[i].srdy = wake_bits(q_n[i].stag, q_n[i].srdy, wk_valid, wk_tag);
    end
    base   = count - CW'(disp_fire);
    slot_b = base + CW'(take[0]);
    if (take[0])
      q_n[IW'(base)] = new_entry(1'b0, ins_tag[0], ins_src_tag[0], ins_src_rdy[0],
                                 wk_valid, wk_tag);
    if (take[1])
      q_n[IW'(slot_b)] = new_entry(1'b1, ins_tag[1], ins_src_tag[1], ins_src_rdy[1],
                                   wk_valid, wk_tag);
    count_n = slot_b + CW'(take[1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      count <= count_n;
      for (int i = 0; i < DEPTH; i++) q[i] <= q_n[i];
    end
  end

endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int DEPTH = 10,
  parameter int RSV   = 2,
  parameter int CW    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CW-1:0]      count,
  input logic [1:0][CW-1:0] occ,
  input logic [1:0]         full,
  input logic [1:0]         ins_valid,
  input logic [1:0]         take,
  input logic               disp_valid
);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  a_r6_reserve_t0: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ[0]) < RSV) |-> !full[0]);

  a_r6_reserve_t1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ[1]) < RSV) |-> !full[1]);

  a_r8_refused_t0: assert property (@(posedge clk) disable iff (!rst_n)
    (full[0] && ins_valid[0]) |=> (occ[0] <= $past(occ[0])));

  a_r8_refused_t1: assert property (@(posedge clk) disable iff (!rst_n)
    (full[1] && ins_valid[1]) |=> (occ[1] <= $past(occ[1])));

  a_r7_double_take_room: assert property (@(posedge clk) disable iff (!rst_n)
    (take == 2'b11) |-> (DEPTH - int'(count) >= 2));

  a_r2_dispatch_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (count != '0));

endmodule

bind dual_thread_issue_queue iq_checker #(.DEPTH(DEPTH), .RSV(RSV), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .count      (count),
  .occ        (occ),
  .full       (full),
  .ins_valid  (ins_valid),
  .take       (take),
  .disp_valid (disp_valid)
);

// File: tb/sim_dual_thread_issue_queue.sv
module sim_dual_thread_issue_queue;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 10;
  localparam int RSV        = 2;
  localparam int TW         = 4;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [1:0]              iv = '0;
  logic [1:0][TW-1:0]      itag = '0;
  logic [1:0][1:0][TW-1:0] istag = '0;
  logic [1:0][1:0]         irdy = '0;
  logic                    wkv = 1'b0;
  logic [TW-1:0]           wkt = '0;
  logic [1:0]              full;
  logic                    disp_valid;
  logic [TW-1:0]           disp_tag;
  logic                    disp_thread;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_thread_issue_queue #(.DEPTH(DEPTH), .RSV(RSV), .TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(iv), .ins_tag(itag), .ins_src_tag(istag),
    .ins_src_rdy(irdy), .wk_valid(wkv), .wk_tag(wkt), .full(full),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_thread(disp_thread)
  );

  typedef struct {
    bit          thr;
    bit [TW-1:0] tag;
    bit [TW-1:0] s0, s1;
    bit          r0, r1;
  } m_t;

  m_t   mq[$];
  bit   mpri = 1'b0;
  bit [1:0] efull;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_occ(bit t);
    int n = 0;
    foreach (mq[i]) if (mq[i].thr == t) n++;
    return n;
  endfunction

  function automatic int m_first_ready();
    foreach (mq[i]) if (mq[i].r0 && mq[i].r1) return i;
    return -1;
  endfunction

  function automatic bit m_contest();
    int o0 = m_occ(0);
    int o1 = m_occ(1);
    int fr = DEPTH - o0 - o1;
    int room0 = fr - ((o1 < RSV) ? RSV - o1 : 0);
    int room1 = fr - ((o0 < RSV) ? RSV - o0 : 0);
    return (fr == 1) && (room0 > 0) && (room1 > 0) && (iv == 2'b11);
  endfunction

  function automatic bit [1:0] m_full();
    int o0 = m_occ(0);
    int o1 = m_occ(1);
    int fr = DEPTH - o0 - o1;
    bit [1:0] f;
    f[0] = (fr - ((o1 < RSV) ? RSV - o1 : 0)) < 1;
    f[1] = (fr - ((o0 < RSV) ? RSV - o0 : 0)) < 1;
    if (m_contest()) begin
      if (mpri) f[0] = 1'b1;
      else      f[1] = 1'b1;
    end
    return f;
  endfunction

  function automatic bit hit(bit [TW-1:0] t);
    return wkv && (wkt == t);
  endfunction

  // Compare outputs with the model, inputs already driven for this cycle
  task automatic settle();
    int e;
    #1;
    efull = m_full();
    e = m_first_ready();
    chk("R2", int'(disp_valid), int'(e >= 0), "disp_valid");
    if (e >= 0) begin
      chk("R2", int'(disp_tag), int'(mq[e].tag), "disp_tag");
      chk("R2", int'(disp_thread), int'(mq[e].thr), "disp_thread");
    end
    chk("R6", int'(full), int'(efull), "full");
  endtask

  task automatic advance();
    bit [1:0] acc = iv & ~efull;
    int e = m_first_ready();
    if (m_contest()) mpri = ~mpri;
    if (e >= 0) mq.delete(e);
    foreach (mq[i]) begin
      if (hit(mq[i].s0)) mq[i].r0 = 1'b1;
      if (hit(mq[i].s1)) mq[i].r1 = 1'b1;
    end
    for (int t = 0; t < 2; t++) begin
      if (acc[t]) begin
        m_t n;
        n.thr = bit'(t);
        n.tag = itag[t];
        n.s0  = istag[t][0];
        n.s1  = istag[t][1];
        n.r0  = irdy[t][0] | hit(istag[t][0]);
        n.r1  = irdy[t][1] | hit(istag[t][1]);
        mq.push_back(n);
      end
    end
    @(posedge clk);
    @(negedge clk);
    iv  = '0;
    wkv = 1'b0;
  endtask

  task automatic put(int t, int tag, int s0, bit r0, int s1, bit r1);
    iv[t]       = 1'b1;
    itag[t]     = TW'(tag);
    istag[t][0] = TW'(s0);
    istag[t][1] = TW'(s1);
    irdy[t][0]  = r0;
    irdy[t][1]  = r1;
  endtask

  task automatic cyc();
    settle();
    advance();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51ED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset
    #1;
    chk("R1", int'(disp_valid), 0, "disp_valid after reset");
    chk("R1", int'(full), 0, "full after reset");
    cyc();

    // R3 / R4: wait on two sources, broadcast one at a time
    put(0, 3, 5, 0, 6, 0); cyc();
    settle(); chk("R3", int'(disp_valid), 0, "no sources ready"); advance();
    wkv = 1; wkt = 5;
    settle(); chk("R3", int'(disp_valid), 0, "one source ready"); advance();
    wkv = 1; wkt = 6;
    settle(); chk("R4", int'(disp_valid), 0, "broadcast cycle"); advance();
    settle(); chk("R4", int'(disp_tag), 3, "dispatch after broadcast"); advance();

    // R4: broadcast in the insertion cycle itself
    put(1, 7, 9, 0, 10, 1); wkv = 1; wkt = 9; cyc();
    settle(); chk("R4", int'(disp_valid), 1, "woken at insert");
    chk("R4", int'(disp_tag), 7, "woken at insert tag"); advance();

    // R5: dual insert, thread 0 older
    put(0, 1, 0, 1, 0, 1); put(1, 2, 0, 1, 0, 1); cyc();
    settle(); chk("R5", int'(disp_thread), 0, "first of pair"); advance();
    settle(); chk("R5", int'(disp_tag), 2, "second of pair"); advance();
    repeat (2) cyc();

    // R6: thread 0 fills up to the reservation held for thread 1
    for (int k = 0; k < DEPTH - RSV; k++) begin put(0, k, 15, 0, 15, 0); cyc(); end
    settle(); chk("R6", int'(full), 1, "thread 0 blocked, thread 1 free"); advance();
    wkv = 1; wkt = 15; cyc();
    repeat (DEPTH) cyc();

    // R7: two last-slot contests, winner alternates
    for (int k = 0; k < 7; k++) begin
      put(0, k, 13, 0, 13, 0);
      if (k < 2) put(1, k + 8, 13, 0, 13, 0);
      cyc();
    end
    put(0, 11, 0, 1, 0, 1); put(1, 12, 0, 1, 0, 1);
    settle(); chk("R7", int'(full), 2, "first contest"); advance();
    cyc();
    put(0, 11, 0, 1, 0, 1); put(1, 12, 0, 1, 0, 1);
    settle(); chk("R7", int'(full), 1, "second contest"); advance();
    cyc();

    // R9 / R8: fill completely, then offer ready micro-ops that must be dropped
    put(1, 12, 13, 0, 13, 0); cyc();
    put(0, 14, 0, 1, 0, 1); put(1, 14, 0, 1, 0, 1);
    settle(); chk("R9", int'(full), 3, "queue at capacity"); advance();
    settle(); chk("R8", int'(disp_valid), 0, "dropped micro-ops absent"); advance();
    wkv = 1; wkt = 13; cyc();
    repeat (DEPTH + 2) cyc();

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int t = 0; t < 2; t++) begin
        if ($urandom_range(9) < 6)
          put(t, $urandom_range(15), $urandom_range(15), $urandom_range(9) < 4,
              $urandom_range(15), $urandom_range(9) < 4);
      end
      wkv = $urandom_range(9) < 7;
      wkt = TW'($urandom_range(15));
      cyc();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule